// File: doc/BRIEF.md
# Load-Multiple Transfer Sequencer

This block carries out a block load from memory into a register file. A single start pulse supplies a base address, the index of the register that holds that base, a 16-bit mask selecting destination registers, an addressing type and a writeback flag. The sequencer then reads one 32-bit word per selected register over a request/acknowledge memory port. It turns each returned word into a register-file write tagged with its destination index.

Registers are always filled in ascending index order, and the lowest selected register always takes the lowest memory address. The addressing type decides whether the block of words sits above or below the base, and whether it starts on the base word or on its neighbour. When writeback is requested, the base register receives the base moved past the whole block once the loads have finished. A done pulse closes every operation.

Top module: `lm_seq`

## Requirements
- R1: While reset is high and after it is released with no start, `busy`, `mem_req`, `rf_we` and `done` are all 0.
- R2: For each set bit of `reg_mask`, exactly one memory read is made, in ascending bit order. Each acknowledged read produces, in the same cycle, `rf_we`=1 with `rf_idx` set to the bit index and `rf_wdata` equal to `mem_rdata`. Successive read addresses rise by 4.
- R3: Type 2'b10 (increment-after): the first read address is `base_addr`.
- R4: Type 2'b11 (increment-before): the first read address is `base_addr`+4.
- R5: Type 2'b00 (decrement-after): the first read address is `base_addr`-4*N+4, where N is the number of set mask bits.
- R6: Type 2'b01 (decrement-before): the first read address is `base_addr`-4*N.
- R7: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack` is seen, so the read survives any number of wait cycles.
- R8: With `wb_en`=1, one extra register write follows the last load, to index `base_idx`. Its value is `base_addr`+4*N for the increment types and `base_addr`-4*N for the decrement types.
- R9: With `wb_en`=0, no register write beyond the N loads occurs.
- R10: When `reg_mask` bit `base_idx` is set, the loaded word is the final value of that register and no writeback write occurs, even with `wb_en`=1.
- R11: `done` is high for exactly one cycle, in the cycle after the last register write of the operation.
- R12: An all-zero `reg_mask` raises `done` in the cycle after the start is taken, with no memory read and no register write, whatever `wb_en` is.
- R13: `start` is ignored while `busy` is high. A pulse during an operation adds no reads or writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base_addr | input | 32 | Byte address held in the base register |
| base_idx | input | 4 | Index of the base register |
| reg_mask | input | 16 | One bit per destination register |
| xfer_mode | input | 2 | Bit 1: increment(1)/decrement(0); bit 0: before(1)/after(0) |
| wb_en | input | 1 | Write the final address back to the base register |
| busy | output | 1 | Operation in progress (including the done cycle) |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each of the four addressing types is run with a different mask shape: a sparse mask, a mask with bits spread across the whole width, a two-bit mask, and a full mask. A wrong start offset, a wrong scan order or a wrong count in the span calculation each show up in a different case. Writeback is tried enabled, disabled and with the base register inside the list. This separates the precedence rule from a plain missing write. Memory latency is varied from zero to several wait cycles to expose request-hold faults. An empty mask, a single-bit mask and a start pulse injected mid-operation cover the edges of the sequencing.

// File: rtl/lm_pkg.sv
package lm_pkg;

    localparam int unsigned WORD_BYTES = 4;

    // bit 1 selects direction (1 = up), bit 0 selects before (1) / after (0)
    typedef enum logic [1:0] {
        XM_DEC_AFTER  = 2'b00,
        XM_DEC_BEFORE = 2'b01,
        XM_INC_AFTER  = 2'b10,
        XM_INC_BEFORE = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WBACK,
        ST_FIN
    } lm_state_e;

    function automatic logic is_increment(input xfer_mode_e m);
        return m[1];
    endfunction

    function automatic logic is_before(input xfer_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/lm_addr_plan.sv
module lm_addr_plan #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic [ADDR_W-1:0]      base,
    input  logic [NREG-1:0]        mask,
    input  lm_pkg::xfer_mode_e     mode,
    output logic [ADDR_W-1:0]      first_addr,
    output logic [ADDR_W-1:0]      final_addr
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(lm_pkg::WORD_BYTES);

    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    assign span = ADDR_W'(cnt) * STEP;

    always_comb begin
        if (lm_pkg::is_increment(mode)) begin
            first_addr = lm_pkg::is_before(mode) ? base + STEP : base;
            final_addr = base + span;
        end else begin
            first_addr = lm_pkg::is_before(mode) ? base - span : base - span + STEP;
            final_addr = base - span;
        end
    end

endmodule

// File: rtl/lm_lowest_pick.sv
module lm_lowest_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [NREG-1:0] below_any;

    // below_any[i] is set when some lower bit is set
    assign below_any[0] = 1'b0;
    for (genvar g = 1; g < NREG; g++) begin : g_prefix
        assign below_any[g] = below_any[g-1] | mask[g-1];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (mask[i] && !below_any[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign last = (mask & (mask - 1'b1)) == '0;

endmodule

// File: rtl/lm_seq.sv
module lm_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [NREG-1:0]   reg_mask,
    input  logic [1:0]        xfer_mode,
    input  logic              wb_en,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              done
);
    import lm_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    lm_state_e         state;
    logic [NREG-1:0]   rem_mask;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] final_q;
    logic [IDX_W-1:0]  base_idx_q;
    logic              wb_q;

    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_last;

    lm_addr_plan #(.ADDR_W(ADDR_W), .NREG(NREG)) u_plan (
        .base       (base_addr),
        .mask       (reg_mask),
        .mode       (xfer_mode_e'(xfer_mode)),
        .first_addr (plan_first),
        .final_addr (plan_final)
    );

    lm_lowest_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .mask (rem_mask),
        .idx  (pick_idx),
        .last (pick_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rem_mask   <= '0;
            cur_addr   <= '0;
            final_q    <= '0;
            base_idx_q <= '0;
            wb_q       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rem_mask   <= reg_mask;
                        cur_addr   <= plan_first;
                        final_q    <= plan_final;
                        base_idx_q <= base_idx;
                        // a loaded base wins over the written-back address
                        wb_q       <= wb_en && !reg_mask[base_idx];
                        state      <= (reg_mask == '0) ? ST_FIN : ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        rem_mask <= rem_mask & (rem_mask - 1'b1);
                        cur_addr <= cur_addr + STEP;
                        if (pick_last) begin
                            state <= wb_q ? ST_WBACK : ST_FIN;
                        end
                    end
                end
                ST_WBACK: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_READ);
    assign mem_addr = cur_addr;
    assign rf_we    = ((state == ST_READ) && mem_ack) || (state == ST_WBACK);
    assign rf_idx   = (state == ST_WBACK) ? base_idx_q : pick_idx;
    assign rf_wdata = (state == ST_WBACK) ? DATA_W'(final_q) : mem_rdata;
    assign done     = (state == ST_FIN);

endmodule

// File: rtl/lm_seq_checker.sv
module lm_seq_checker #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [NREG-1:0]   reg_mask,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              rf_we,
    input logic              done
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_empty_list_R12: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (reg_mask == '0) |=> done && !mem_req && !rf_we);

    assert_no_restart_R13: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

    assert_req_inside_op_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy && !done);

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !rf_we && !done);

endmodule

bind lm_seq lm_seq_checker #(.ADDR_W(ADDR_W), .NREG(NREG)) u_lm_seq_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .reg_mask (reg_mask),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .rf_we    (rf_we),
    .done     (done)
);

// File: tb/tb_lm_seq.sv
module tb_lm_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [3:0]  base_idx = '0;
    logic [15:0] reg_mask = '0;
    logic [1:0]  xfer_mode = '0;
    logic        wb_en = 1'b0;
    logic        busy, mem_req, rf_we, done;
    logic [31:0] mem_addr, rf_wdata;
    logic [3:0]  rf_idx;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    lm_seq dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .base_idx(base_idx), .reg_mask(reg_mask), .xfer_mode(xfer_mode),
        .wb_en(wb_en), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_wdata(rf_wdata), .done(done)
    );

    typedef struct {
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] addr;
        bit          is_wb;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    failures = 0;
    int    mem_delay = 0;
    int    reads_seen = 0;
    int    reads_exp = 0;
    int    ops_done = 0;
    bit    prev_we = 1'b0;
    bit    prev_done = 1'b0;
    string cur_tag = "R3";

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: ack after mem_delay wait cycles, one-cycle ack
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (rst || mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= mem_delay) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_word(mem_addr);
            end else begin
                wait_cnt++;
            end
        end
    end

    // monitor: compares register writes and completion against the queue
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (prev_done) begin
                check(!done, "R11", "done longer than one cycle", {31'b0, done}, 32'h0);
            end
            if (mem_req && mem_ack) reads_seen++;
            if (rf_we) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R13", "unexpected register write", {28'b0, rf_idx}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.is_wb) begin
                        check(rf_idx == e.idx, "R8", "writeback index", {28'b0, rf_idx}, {28'b0, e.idx});
                        check(rf_wdata == e.data, "R8", "writeback value", rf_wdata, e.data);
                    end else begin
                        check(mem_addr == e.addr, cur_tag, "read address", mem_addr, e.addr);
                        check(rf_idx == e.idx, "R2", "load index", {28'b0, rf_idx}, {28'b0, e.idx});
                        check(rf_wdata == e.data, "R2", "load data", rf_wdata, e.data);
                    end
                end
            end
            if (done) begin
                check(sb_q.size() == 0, "R11", "writes left at done", sb_q.size(), 32'h0);
                check(prev_we == (reads_exp != 0), "R11", "write in cycle before done",
                      {31'b0, prev_we}, {31'b0, reads_exp != 0});
                check(reads_seen == reads_exp, "R2", "read count", reads_seen, reads_exp);
                reads_seen = 0;
                ops_done++;
            end
            prev_we   = rf_we;
            prev_done = done;
        end
    end

    task automatic run_op(input logic [31:0] base, input logic [3:0] bidx,
                          input logic [15:0] mask, input logic [1:0] mode,
                          input bit wb, input int delay, input bit poke_busy);
        int n = 0;
        int target;
        logic [31:0] a;
        logic [31:0] fin;
        for (int i = 0; i < 16; i++) if (mask[i]) n++;
        case (mode)
            2'b10: begin a = base;              fin = base + 32'(4 * n); cur_tag = "R3"; end
            2'b11: begin a = base + 32'd4;      fin = base + 32'(4 * n); cur_tag = "R4"; end
            2'b00: begin a = base - 32'(4 * n) + 32'd4; fin = base - 32'(4 * n); cur_tag = "R5"; end
            default: begin a = base - 32'(4 * n); fin = base - 32'(4 * n); cur_tag = "R6"; end
        endcase
        for (int i = 0; i < 16; i++) begin
            if (mask[i]) begin
                sb_q.push_back('{idx: 4'(i), data: mem_word(a), addr: a, is_wb: 1'b0});
                a = a + 32'd4;
            end
        end
        if (wb && n != 0 && !mask[bidx]) begin
            sb_q.push_back('{idx: bidx, data: fin, addr: 32'h0, is_wb: 1'b1});
        end
        reads_exp = n;
        mem_delay = delay;
        target = ops_done + 1;
        @(negedge clk);
        base_addr = base; base_idx = bidx; reg_mask = mask;
        xfer_mode = mode; wb_en = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mask == '0) begin
            #2;
            check(done == 1'b1, "R12", "done one cycle after empty start", {31'b0, done}, 32'h1);
            check(mem_req == 1'b0, "R12", "read on empty list", {31'b0, mem_req}, 32'h0);
        end
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            base_addr = 32'h0000_9000; reg_mask = 16'hFFFF; wb_en = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (ops_done < target) @(negedge clk);
        repeat (2) @(negedge clk);
        #3;
        check(!busy, "R13", "idle after operation", {31'b0, busy}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check({busy, mem_req, rf_we, done} == 4'b0, "R1", "outputs in reset",
              {28'b0, busy, mem_req, rf_we, done}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        check({busy, mem_req, rf_we, done} == 4'b0, "R1", "outputs after reset",
              {28'b0, busy, mem_req, rf_we, done}, 32'h0);

        run_op(32'h0000_1000, 4'd13, 16'h00F1, 2'b10, 1'b1, 0, 1'b0); // R3 R8
        run_op(32'h0000_2000, 4'd2,  16'h8421, 2'b11, 1'b1, 2, 1'b0); // R4 R7 R8
        run_op(32'h0000_3000, 4'd9,  16'h0006, 2'b00, 1'b1, 1, 1'b0); // R5 R8
        run_op(32'h0000_8000, 4'd0,  16'hFFFF, 2'b01, 1'b1, 0, 1'b0); // R6 R10
        run_op(32'h0000_4000, 4'd3,  16'h0110, 2'b01, 1'b0, 3, 1'b0); // R9
        run_op(32'h0000_5000, 4'd4,  16'h0000, 2'b10, 1'b1, 0, 1'b0); // R12
        run_op(32'h0000_6000, 4'd7,  16'h0001, 2'b10, 1'b1, 5, 1'b0); // single bit, R7
        run_op(32'h0000_7000, 4'd14, 16'h0C03, 2'b11, 1'b1, 1, 1'b1); // R13
        run_op(32'h0000_A000, 4'd5,  16'h0020, 2'b00, 1'b1, 0, 1'b0); // R10 with DA

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule